// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small microcontroller core. Every subroutine call, and every interrupt the block chooses to acknowledge, stores the current program counter on top of an eight-level stack. Every return, from a subroutine or from an interrupt routine, removes the newest entry. The entry removed is presented combinationally on `ret_pc` in the same cycle, so the core can load it into its program counter. Each push or pop completes in a single clock. The stack and its pointer have no software path: only the call, return and acknowledge events change them.

The stack is built as a ring with a write pointer and an occupancy count. When a call arrives on a full stack, the slot holding the oldest address is reused, so the eight newest return addresses always survive.

Interrupts are handled differently from calls. A pending request, held by the interrupt controller, is acknowledged only while the stack has a free level. If the stack is full, the request simply waits. The first return that frees a level lets the acknowledge through on the following cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset `empty` is 1, `full` is 0 and `ret_pc` reads 0.
- R2: A push (a call, or an interrupt acknowledge) stores `pc_i`. From the next cycle `ret_pc` shows that value as the top entry, and entries come back in last-in, first-out order.
- R3: A return on a non-empty stack presents the newest entry on `ret_pc` in the same cycle and lowers the occupancy by one. `empty` is 1 exactly when the occupancy is zero.
- R4: `full` is 1 exactly when `DEPTH` (8) entries are held.
- R5: A call on a full stack discards the oldest entry and keeps the `DEPTH` most recent addresses. `full` stays 1.
- R6: `irq_ack` is 1 exactly when `irq_req` is 1, the stack is not full, and neither `call_i` nor `ret_i` is active in that cycle. An acknowledge pushes `pc_i`.
- R7: While `full` is 1, `irq_ack` stays 0 even with `irq_req` held. After a return frees a level, the held request is acknowledged on the next cycle.
- R8: A return on an empty stack leaves the stack empty. `ret_pc` then repeats the value most recently removed from the stack, which is 0 after reset.
- R9: `call_i` and `ret_i` together return the current top entry on `ret_pc` and replace it with `pc_i`, leaving the occupancy unchanged. On an empty stack, `pc_i` becomes the value that a later empty return reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call: push `pc_i` |
| ret_i | input | 1 | Return (subroutine or interrupt): pop |
| irq_req | input | 1 | Pending unmasked interrupt from the controller |
| pc_i | input | PC_W | Program counter value to store |
| ret_pc | output | PC_W | Entry returned on a pop (current top) |
| irq_ack | output | 1 | Interrupt acknowledged this cycle |
| full | output | 1 | All levels occupied |
| empty | output | 1 | No levels occupied |

## Verification
Several properties are checked on every cycle:
- the occupancy never exceeds the depth;
- `full` persists under a push on a full stack;
- an empty pop leaves the pointer where it was;
- a combined push and pop holds the occupancy;
- `irq_ack` never rises while `full` is set;
- a pushed value appears on `ret_pc` one cycle later.

Other behaviours show only in the bench's scenarios, where a reference queue tracks the stack:
- which address is lost on overflow and the exact order in which addresses come back;
- the stale value an empty pop returns;
- the one-cycle release of a held interrupt after a return.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_SWAP = 2'd3
   } stk_op_e;

   function automatic stk_op_e decode_op(input logic push, input logic pop);
      case ({pop, push})
         2'b01:   return OP_PUSH;
         2'b10:   return OP_POP;
         2'b11:   return OP_SWAP;
         default: return OP_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
   import rstk_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_push,
   input  logic             do_pop,
   output logic             we,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic             full,
   output logic             empty
);

   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [PTR_W-1:0] wp_q, wp_d, top_idx, next_idx;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   stk_op_e          op;

   assign op       = decode_op(do_push, do_pop);
   assign full     = (cnt_q == FULL_CNT);
   assign empty    = (cnt_q == '0);
   assign top_idx  = (wp_q == '0) ? LAST_IDX : wp_q - 1'b1;
   assign next_idx = (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
   assign rd_idx   = empty ? wp_q : top_idx;

   always_comb begin
      wp_d   = wp_q;
      cnt_d  = cnt_q;
      we     = 1'b0;
      wr_idx = wp_q;
      case (op)
         OP_PUSH: begin
            we    = 1'b1;
            wp_d  = next_idx;
            cnt_d = full ? cnt_q : cnt_q + 1'b1;
         end
         OP_POP: begin
            if (!empty) begin
               wp_d  = top_idx;
               cnt_d = cnt_q - 1'b1;
            end
         end
         OP_SWAP: begin
            we     = 1'b1;
            wr_idx = empty ? wp_q : top_idx;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         cnt_q <= '0;
      end else begin
         wp_q  <= wp_d;
         cnt_q <= cnt_d;
      end
   end

   a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   a_r5_full_push_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && do_push && !do_pop) |=> full);

   a_r3_pop_lowers_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && do_pop && !do_push) |=> (cnt_q == $past(cnt_q) - 1'b1));

   a_r8_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && do_pop && !do_push) |=> (empty && $stable(wp_q)));

   a_r9_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && do_pop) |=> $stable(cnt_q));

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
   parameter int PC_W        = 11,
   parameter int DEPTH       = 8,
   parameter bit STORE_RESET = 1'b1,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PTR_W-1:0] wr_idx,
   input  logic [PC_W-1:0]  wr_data,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [PC_W-1:0]  rd_data
);

   logic [PC_W-1:0] slot_q [DEPTH];

   assign rd_data = slot_q[rd_idx];

   generate
      if (STORE_RESET) begin : g_rst_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            end else if (we) begin
               slot_q[wr_idx] <= wr_data;
            end
         end
      end else begin : g_plain_store
         always_ff @(posedge clk) begin
            if (we) slot_q[wr_idx] <= wr_data;
         end
      end
   endgenerate

endmodule

// File: rtl/rstk_irq_gate.sv
module rstk_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_req,
   input  logic call_i,
   input  logic ret_i,
   input  logic full,
   output logic irq_ack
);

   assign irq_ack = irq_req && !full && !call_i && !ret_i;

   a_r7_no_ack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !irq_ack);

   a_r7_ret_frees_level: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ret_i && !call_i) |=> !full);

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
   parameter int PC_W        = 11,
   parameter int DEPTH       = 8,
   parameter bit STORE_RESET = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_i,
   input  logic            ret_i,
   input  logic            irq_req,
   input  logic [PC_W-1:0] pc_i,
   output logic [PC_W-1:0] ret_pc,
   output logic            irq_ack,
   output logic            full,
   output logic            empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ret_addr_stack: DEPTH must be at least 2");
      end
      if (PC_W < 1) begin : g_bad_width
         $error("ret_addr_stack: PC_W must be at least 1");
      end
   endgenerate

   logic             do_push;
   logic             we;
   logic [PTR_W-1:0] wr_idx, rd_idx;

   assign do_push = call_i || irq_ack;

   rstk_irq_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_req (irq_req),
      .call_i  (call_i),
      .ret_i   (ret_i),
      .full    (full),
      .irq_ack (irq_ack)
   );

   rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_push (do_push),
      .do_pop  (ret_i),
      .we      (we),
      .wr_idx  (wr_idx),
      .rd_idx  (rd_idx),
      .full    (full),
      .empty   (empty)
   );

   rstk_store #(.PC_W(PC_W), .DEPTH(DEPTH), .STORE_RESET(STORE_RESET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .wr_idx  (wr_idx),
      .wr_data (pc_i),
      .rd_idx  (rd_idx),
      .rd_data (ret_pc)
   );

   a_r2_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && !ret_i) |=> (ret_pc == $past(pc_i)));

   a_r6_ack_excludes_ops: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (irq_req && !call_i && !ret_i));

endmodule

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;

   localparam int PC_W  = 11;
   localparam int DEPTH = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            call_i = 1'b0, ret_i = 1'b0, irq_req = 1'b0;
   logic [PC_W-1:0] pc_i = '0;
   logic [PC_W-1:0] ret_pc;
   logic            irq_ack, full, empty;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [PC_W-1:0] mq[$];
   logic [PC_W-1:0] last_val = '0;

   always #5 clk = ~clk;

   ret_addr_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .irq_req(irq_req), .pc_i(pc_i), .ret_pc(ret_pc),
      .irq_ack(irq_ack), .full(full), .empty(empty)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [PC_W-1:0] model_top();
      if (mq.size() == 0) return last_val;
      return mq[mq.size()-1];
   endfunction

   function automatic bit model_ack(input bit c, input bit r, input bit q);
      return q && (mq.size() < DEPTH) && !c && !r;
   endfunction

   // one cycle: drive after negedge, check combinational outputs, update model
   task automatic step(input bit c, input bit r, input bit q,
                       input logic [PC_W-1:0] pc, input string tag);
      bit              exp_ack;
      logic [PC_W-1:0] exp_pc;
      string           t;
      @(negedge clk);
      call_i = c; ret_i = r; irq_req = q; pc_i = pc;
      #1;
      exp_ack = model_ack(c, r, q);
      exp_pc  = model_top();
      chk("R4", "full", full, int'(mq.size() == DEPTH));
      chk("R3", "empty", empty, int'(mq.size() == 0));
      if (q && mq.size() == DEPTH) chk("R7", "irq_ack held", irq_ack, exp_ack);
      else                         chk("R6", "irq_ack", irq_ack, exp_ack);
      if (tag != "")            t = tag;
      else if (c && r)          t = "R9";
      else if (r && mq.size()==0) t = "R8";
      else if (r)               t = "R3";
      else                      t = "R2";
      if (r || mq.size() != 0) chk(t, "ret_pc", ret_pc, exp_pc);
      // model update
      if ((c || exp_ack) && r) begin
         if (mq.size() == 0) last_val = pc;
         else mq[mq.size()-1] = pc;
      end else if (c || exp_ack) begin
         if (mq.size() == DEPTH) void'(mq.pop_front());
         mq.push_back(pc);
      end else if (r) begin
         if (mq.size() != 0) last_val = mq.pop_back();
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1", "empty at reset", empty, 1);
      chk("R1", "full at reset", full, 0);
      chk("R1", "ret_pc at reset", ret_pc, 0);
      rst_n = 1'b1;

      // R8: empty pop after reset returns 0
      step(0, 1, 0, 11'h123, "R8");
      // R2/R3: LIFO fill then drain
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0, PC_W'(11'h100 + i), "R2");
      // R7: full holds interrupt, return frees a level, ack next cycle
      step(0, 0, 1, 11'h7AA, "R7");
      step(0, 0, 1, 11'h7AB, "R7");
      step(0, 1, 1, 11'h7AC, "R3");
      step(0, 0, 1, 11'h7AD, "R7");
      step(0, 0, 0, 11'h000, "R6");
      // R5: calls on a full stack drop the oldest
      for (int i = 0; i < 3; i++) step(1, 0, 0, PC_W'(11'h200 + i), "R5");
      for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 11'h000, "R5");
      // R8: empty pop repeats last removed value
      step(0, 1, 0, 11'h000, "R8");
      step(0, 1, 0, 11'h000, "R8");
      // R9: swap on empty and on non-empty
      step(1, 1, 0, 11'h3C3, "R9");
      step(0, 1, 0, 11'h000, "R9");
      step(1, 0, 0, 11'h055, "R2");
      step(1, 1, 0, 11'h0AA, "R9");
      step(0, 1, 0, 11'h000, "R9");

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         bit c, r, q;
         int unsigned v;
         v = $urandom;
         c = ($urandom % 100) < 35;
         r = ($urandom % 100) < 30;
         q = ($urandom % 100) < 40;
         step(c, r, q, PC_W'(v), "");
      end

      @(negedge clk);
      call_i = 0; ret_i = 0; irq_req = 0;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule